// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block owns the instruction address of a small processor core. Once per instruction period it chooses the next address. The candidates are the following address, an unconditional jump target, or a jump target that applies only when a tested register meets a condition. A call also saves the address after the call on a dedicated hardware stack. A return takes the saved address back from that stack. A built-in comparator sorts the tested 32-bit register into exactly one of three classes: zero, positive or negative.

The core runs its datapath on a fast base clock and issues an advance strobe once per instruction. The PC and the stack change only on a base-clock edge where that strobe is high. No data stream passes through this block. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. A stack misuse, meaning a push onto a full stack or a pop from an empty one, does not stop the sequencer. It raises a sticky error flag and leaves the stack contents as they were.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) sets pc_o to 0, clears err_o and empties the stack.
- R2: On an edge where step_i is low, pc_o, err_o and the stack all keep their values, whatever the other inputs are.
- R3: With step_i high and kind_i equal to 0 (sequential) or 7 (unused), pc_o becomes pc_o+1 modulo 2^22.
- R4: With step_i high and kind_i equal to 1 (jump), pc_o becomes target_i.
- R5: Codes 2, 3 and 4 load target_i only when test_i is zero, positive or negative respectively. Sign is judged in two's complement: bit 31 set means negative, and a nonzero value with bit 31 clear is positive. When the condition is false, pc_o becomes pc_o+1.
- R6: With step_i high and kind_i equal to 5 (call), pc_o becomes target_i and pc_o+1 is pushed onto the stack.
- R7: With step_i high and kind_i equal to 6 (return) and a non-empty stack, pc_o becomes the most recently pushed entry and that entry is popped. Entries come back in last-in first-out order, up to 8 deep.
- R8: A call made while 8 entries are held still loads target_i, leaves the stack unchanged and sets err_o.
- R9: A return made on an empty stack sets pc_o to pc_o+1, leaves the stack empty and sets err_o.
- R10: Once set, err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Instruction-rate advance strobe |
| kind_i | input | 3 | Branch kind: 0 seq, 1 jump, 2 if-zero, 3 if-positive, 4 if-negative, 5 call, 6 return, 7 seq |
| target_i | input | 22 | Jump or call target address |
| test_i | input | 32 | Register value tested by conditional jumps |
| pc_o | output | 22 | Current program counter |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
Every result is due exactly one base-clock edge after the strobed edge that causes it. The PC, the stack contents and the error flag all update together at that edge. The bench drives inputs at the falling edge and updates its behavioural model at the same moment. It compares pc_o and err_o at the next falling edge, so each comparison falls between the one rising edge that acts on a stimulus and the next. The contents of the stack are observed only through the addresses that later returns produce. Because the comparison runs on every cycle, it also covers the idle cycles in which nothing may change.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 32;
  localparam int STACK_DEPTH = 8;

  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_JMP  = 3'd1,
    BK_JZ   = 3'd2,
    BK_JP   = 3'd3,
    BK_JN   = 3'd4,
    BK_CALL = 3'd5,
    BK_RET  = 3'd6,
    BK_NONE = 3'd7
  } branch_kind_e;

  typedef struct packed {
    logic is_zero;
    logic is_pos;
    logic is_neg;
  } sign_class_t;
endpackage

// File: rtl/pcseq_classifier.sv
module pcseq_classifier
  import pcseq_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] value_i,
  output sign_class_t  class_o
);
  logic nonzero;

  always_comb begin
    nonzero         = |value_i;
    class_o.is_zero = !nonzero;
    class_o.is_neg  = value_i[W-1];
    class_o.is_pos  = nonzero && !value_i[W-1];
  end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 22
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          misuse_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;
  logic          do_push;
  logic          do_pop;

  always_comb begin
    empty_o  = (cnt == '0);
    full_o   = (cnt == CW'(DEPTH));
    wr_idx   = IW'(cnt);
    rd_idx   = IW'(cnt - CW'(1));
    top_o    = mem[rd_idx];
    do_push  = push_i && !full_o;
    do_pop   = pop_i && !empty_o;
    misuse_o = (push_i && full_o) || (pop_i && empty_o);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt <= '0;
    end else if (do_push) begin
      cnt <= cnt + CW'(1);
    end else if (do_pop) begin
      cnt <= cnt - CW'(1);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          mem[g] <= '0;
        end else if (do_push && (wr_idx == IW'(g))) begin
          mem[g] <= data_i;
        end
      end
    end
  endgenerate

  assert_depth_bound_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= CW'(DEPTH));

  assert_push_grows_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (push_i && !full_o) |=> (cnt == $past(cnt) + CW'(1)));

  assert_pop_shrinks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (pop_i && !push_i && !empty_o) |=> (cnt == $past(cnt) - CW'(1)));

  assert_full_push_keeps_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (push_i && full_o) |=> $stable(cnt));
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] target_i,
  input  sign_class_t   class_i,
  input  logic [AW-1:0] top_i,
  input  logic          empty_i,
  output logic [AW-1:0] next_pc_o,
  output logic [AW-1:0] ret_addr_o,
  output logic          push_o,
  output logic          pop_o
);
  branch_kind_e kind;
  logic         take;

  always_comb begin
    kind       = branch_kind_e'(kind_i);
    ret_addr_o = pc_i + AW'(1);
    push_o     = 1'b0;
    pop_o      = 1'b0;
    take       = 1'b0;
    unique case (kind)
      BK_JMP:  take = 1'b1;
      BK_JZ:   take = class_i.is_zero;
      BK_JP:   take = class_i.is_pos;
      BK_JN:   take = class_i.is_neg;
      BK_CALL: begin
        take   = 1'b1;
        push_o = 1'b1;
      end
      BK_RET:  pop_o = 1'b1;
      default: take = 1'b0;
    endcase
    if (take) begin
      next_pc_o = target_i;
    end else if (pop_o && !empty_i) begin
      next_pc_o = top_i;
    end else begin
      next_pc_o = ret_addr_o;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int DEPTH = STACK_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          step_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] target_i,
  input  logic [DW-1:0] test_i,
  output logic [AW-1:0] pc_o,
  output logic          err_o
);
  sign_class_t   cls;
  logic [AW-1:0] next_pc;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] top;
  logic          empty;
  logic          full;
  logic          push_req;
  logic          pop_req;
  logic          misuse;

  pcseq_classifier #(.W(DW)) u_cls (
    .value_i(test_i),
    .class_o(cls)
  );

  pcseq_next #(.AW(AW)) u_next (
    .kind_i    (kind_i),
    .pc_i      (pc_o),
    .target_i  (target_i),
    .class_i   (cls),
    .top_i     (top),
    .empty_i   (empty),
    .next_pc_o (next_pc),
    .ret_addr_o(ret_addr),
    .push_o    (push_req),
    .pop_o     (pop_req)
  );

  pcseq_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .push_i  (step_i && push_req),
    .pop_i   (step_i && pop_req),
    .data_i  (ret_addr),
    .top_o   (top),
    .empty_o (empty),
    .full_o  (full),
    .misuse_o(misuse)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_o  <= '0;
      err_o <= 1'b0;
    end else if (step_i) begin
      pc_o <= next_pc;
      if (misuse) begin
        err_o <= 1'b1;
      end
    end
  end

  assert_class_onehot_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones({cls.is_zero, cls.is_pos, cls.is_neg}) == 1);

  assert_hold_pc_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> ($stable(pc_o) && $stable(err_o)));

  assert_seq_inc_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && (kind_i == 3'd0)) |=> (pc_o == $past(pc_o) + AW'(1)));

  assert_jump_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && (kind_i == 3'd1)) |=> (pc_o == $past(target_i)));

  assert_call_target_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && (kind_i == 3'd5)) |=> (pc_o == $past(target_i)));

  assert_overflow_flag_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && (kind_i == 3'd5) && full) |=> err_o);

  assert_underflow_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && (kind_i == 3'd6) && empty) |=> (err_o && (pc_o == $past(pc_o) + AW'(1))));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o);
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam int AW = 22;
  localparam int DW = 32;
  localparam logic [AW-1:0] AMASK = '1;

  logic          clk = 1'b0;
  logic          rst;
  logic          step;
  logic [2:0]    kind;
  logic [AW-1:0] target;
  logic [DW-1:0] test;
  logic [AW-1:0] pc;
  logic          err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [AW-1:0] m_pc;
  logic          m_err;
  logic [AW-1:0] m_stk[$];
  string         m_tag;

  always #2 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk_i   (clk),
    .rst_i   (rst),
    .step_i  (step),
    .kind_i  (kind),
    .target_i(target),
    .test_i  (test),
    .pc_o    (pc),
    .err_o   (err)
  );

  function automatic string tag_of(input logic r, input logic s, input logic [2:0] k,
                                   input bit misuse);
    if (r) return "R1";
    if (!s) return "R2";
    if (misuse) return (k == 3'd5) ? "R8" : "R9";
    case (k)
      3'd1: return "R4";
      3'd2, 3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R3";
    endcase
  endfunction

  // Reference model: the expected state after the next rising edge.
  task automatic model_step();
    bit misuse = 1'b0;
    bit take;
    logic [AW-1:0] inc = (m_pc + 1) & AMASK;
    if (rst) begin
      m_pc = '0; m_err = 1'b0; m_stk.delete();
    end else if (step) begin
      take = (kind == 3'd1) || (kind == 3'd5) ||
             (kind == 3'd2 && test == 0) ||
             (kind == 3'd3 && test != 0 && !test[31]) ||
             (kind == 3'd4 && test[31]);
      if (kind == 3'd5) begin
        if (m_stk.size() >= 8) misuse = 1'b1;
        else m_stk.push_back(inc);
      end
      if (take) m_pc = target;
      else if (kind == 3'd6) begin
        if (m_stk.size() == 0) begin misuse = 1'b1; m_pc = inc; end
        else m_pc = m_stk.pop_back();
      end else m_pc = inc;
      if (misuse) m_err = 1'b1;
    end
    m_tag = tag_of(rst, step, kind, misuse);
    if (m_err && !misuse && !rst && m_tag != "R2") m_tag = {m_tag, "/R10"};
  endtask

  task automatic compare();
    n_cmp++;
    if (pc !== m_pc || err !== m_err) begin
      n_bad++;
      $display("FAIL %s: pc=%h err=%b expected pc=%h err=%b", m_tag, pc, err, m_pc, m_err);
    end
  endtask

  task automatic op(input logic r, input logic s, input logic [2:0] k,
                    input logic [AW-1:0] t, input logic [DW-1:0] v);
    rst = r; step = s; kind = k; target = t; test = v;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst = 1'b1; step = 1'b0; kind = '0; target = '0; test = '0;
    m_pc = '0; m_err = 1'b0; m_tag = "R1";
    @(negedge clk);
    // R1: reset state
    op(1, 0, 0, 22'h1234, 0);
    // R3: sequential, code 7 too
    op(0, 1, 0, 0, 0);
    op(0, 1, 7, 22'h3ff, 0);
    // R2: no strobe, other inputs busy
    op(0, 0, 1, 22'h0aaaa, 0);
    op(0, 0, 5, 22'h01111, 0);
    op(0, 0, 6, 0, 0);
    // R4: jump, then wrap of R3
    op(0, 1, 1, 22'h3fffff, 0);
    op(0, 1, 0, 0, 0);
    // R5: conditional corners
    op(0, 1, 2, 22'h100, 32'h0);
    op(0, 1, 2, 22'h200, 32'h1);
    op(0, 1, 3, 22'h300, 32'h7fffffff);
    op(0, 1, 3, 22'h340, 32'h0);
    op(0, 1, 3, 22'h380, 32'h80000000);
    op(0, 1, 4, 22'h400, 32'h80000000);
    op(0, 1, 4, 22'h440, 32'h0);
    op(0, 1, 4, 22'h480, 32'h00000001);
    op(0, 1, 4, 22'h4c0, 32'hffffffff);
    // R6/R7: nested calls to full depth, then R8 overflow
    for (int i = 0; i < 8; i++) op(0, 1, 5, AW'(22'h1000 + i * 22'h10), 0);
    op(0, 1, 5, 22'h2000, 0);
    op(0, 1, 5, 22'h2100, 0);
    // R7: LIFO unwind
    for (int i = 0; i < 8; i++) op(0, 1, 6, 0, 0);
    // R9: underflow, R10 sticky
    op(0, 1, 6, 0, 0);
    op(0, 1, 0, 0, 0);
    op(0, 1, 1, 22'h55, 0);
    // R1: reset clears flag and stack
    op(1, 1, 5, 22'h777, 0);
    op(0, 1, 6, 0, 0);
    op(1, 0, 0, 0, 0);
    // Mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] v;
      case ($urandom_range(0, 4))
        0: v = 0;
        1: v = 32'h80000000;
        2: v = 32'h7fffffff;
        default: v = $urandom();
      endcase
      op(($urandom_range(0, 299) == 0), ($urandom_range(0, 3) != 0),
         3'($urandom_range(0, 7)), AW'($urandom()), v);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule